// File: doc/BRIEF.md
# Capture-Compare PWM Timer Core

The core is a free-running up-counter with a programmable power-of-two clock divider. It can either reload a start value on wrap or stop after one pass. A compare unit flags the counter reaching a programmed value. The core drives a waveform output that pulses or toggles on wrap and/or compare events, and it time-stamps edges seen on an asynchronous capture input.

All behaviour is selected through a 15-bit control word. Other inputs supply the reload value, the compare value, a direct counter write and a reload strobe. A capture-clear strobe re-arms the capture logic. Event outputs are one-cycle pulses that can feed an interrupt or wake-up unit elsewhere.

Top module: `ccp_timer_core`

Control word bits: 0 run, 1 reload-on-wrap, 4:2 divider code D, 5 divider enable, 6 compare enable, 7 idle output level, 9:8 capture edge select (0 none, 1 rising, 2 falling, 3 both), 11:10 output event select (0 none, 1 wrap, 2 wrap or compare, 3 treated as none), 12 output style (0 pulse, 1 toggle), 13 capture slot (0 first event, 1 second event), 14 pin direction.

## Requirements
- R1: After a synchronous reset, count, both capture values and all event outputs are 0, and the output sits at the idle level (bit 7).
- R2: With bit 0 low the count holds. With bit 0 high and bit 5 low, it advances by one on every clock.
- R3: With bit 5 high, the count advances once every 2^(D+1) clocks while running. The divider restarts from zero whenever the counter is stopped.
- R4: When a step leaves the all-ones value with bit 1 high, the count takes the reload value, and ev_ovf pulses high for one cycle, in the cycle after that step.
- R5: When a step leaves the all-ones value with bit 1 low, the count goes to 0 and stays there. Counting resumes only after bit 0 has been low for at least one cycle and is raised again.
- R6: cnt_wr_en loads cnt_wr_val and takes priority over trig_wr, which loads the reload value. Either one suppresses the step of that cycle and its events.
- R7: With bit 6 high, ev_match pulses in the cycle after a step lands the count on match_val. A written or reload-strobed value raises no match.
- R8: cap_in passes through a two-flop synchroniser. The edges selected by bits 9:8 are events, and code 0 yields none.
- R9: With bit 13 low, the first event stores the pre-edge count in cap_first. With bit 13 high, the second event stores it in cap_second. ev_cap pulses once, and further events are ignored until cap_clr, which wins over a same-cycle event.
- R10: The output equals the idle level while the counter is not running or bits 11:10 select no events.
- R11: In pulse style, the output is the inverse of the idle level from a divided tick carrying a selected event until the next divided tick.
- R12: In toggle style, the output inverts relative to its previous level on each divided tick carrying a selected event.
- R13: pin_is_input mirrors bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 15 | Control word |
| load_val | input | CNT_W | Reload value |
| match_val | input | CNT_W | Compare value |
| cnt_wr_en | input | 1 | Direct counter write strobe |
| cnt_wr_val | input | CNT_W | Direct counter write value |
| trig_wr | input | 1 | Reload-now strobe |
| cap_in | input | 1 | Asynchronous capture input |
| cap_clr | input | 1 | Capture re-arm strobe |
| count | output | CNT_W | Counter value |
| cap_first | output | CNT_W | First-event capture value |
| cap_second | output | CNT_W | Second-event capture value |
| pwm_out | output | 1 | Waveform output |
| pin_is_input | output | 1 | Pin direction, 1 = input |
| ev_match | output | 1 | Compare event pulse |
| ev_ovf | output | 1 | Wrap event pulse |
| ev_cap | output | 1 | Capture event pulse |

## Verification
The bench instantiates the core with CNT_W set to 8. This puts the wrap from all ones, the reload-versus-halt choice and wrap-triggered waveforms within a few hundred clocks. Divider codes 0 and 3 are exercised, which covers the tick-spacing logic without long runs. Every capture edge mode is run with both slot choices, and with clears placed both between and during event trains.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    localparam int PTV_W  = 3;
    localparam int DIV_W  = 1 << PTV_W;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } capm_e;

    typedef enum logic [1:0] {
        TRG_NONE    = 2'd0,
        TRG_OVF     = 2'd1,
        TRG_OVF_MAT = 2'd2,
        TRG_RSV     = 2'd3
    } trg_e;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_ONE  = 2'd1,
        SLOT_DONE = 2'd2
    } slot_e;

    typedef struct packed {
        logic             pin_in;
        logic             cap_sec;
        logic             toggle;
        trg_e             trg;
        capm_e            capm;
        logic             idle_hi;
        logic             cmp_en;
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
        logic             reload;
        logic             start;
    } ctl_t;

    function automatic logic [DIV_W-1:0] div_limit(input logic [PTV_W-1:0] code);
        logic [DIV_W:0] span;
        logic [DIV_W:0] lim;
        span = (DIV_W+1)'(1) << (32'(code) + 1);
        lim  = span - (DIV_W+1)'(1);
        return lim[DIV_W-1:0];
    endfunction

    function automatic logic trg_active(input trg_e t);
        return (t == TRG_OVF) || (t == TRG_OVF_MAT);
    endfunction

    function automatic logic trg_hits(input trg_e t, input logic wrap, input logic hit);
        return ((t == TRG_OVF) && wrap) || ((t == TRG_OVF_MAT) && (wrap || hit));
    endfunction

endpackage

// File: rtl/ccp_prescaler.sv
module ccp_prescaler
    import ccp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre_en,
    input  logic [PTV_W-1:0] ptv,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = div_limit(ptv);
        tick = run && (!pre_en || (div_q == lim));
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) div_q <= '0;
        else                     div_q <= div_q + DIV_W'(1);
    end

    // after a divided tick, the next clock cannot tick again (limit >= 1)
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && pre_en) |=> !(tick && pre_en));

endmodule

// File: rtl/ccp_counter.sv
module ccp_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             reload,
    input  logic             cmp_en,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             trg_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             wrap,
    output logic             hit,
    output logic             ev_ovf,
    output logic             ev_match
);
    logic [CNT_W-1:0] count_q, nxt;
    logic             halt_q, step;

    always_comb begin
        run  = start && !halt_q;
        step = tick && !wr_en && !trg_wr;
        wrap = step && (&count_q);
        if (wr_en)       nxt = wr_val;
        else if (trg_wr) nxt = load_val;
        else if (wrap)   nxt = reload ? load_val : '0;
        else if (step)   nxt = count_q + CNT_W'(1);
        else             nxt = count_q;
        hit = cmp_en && step && (nxt == match_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            halt_q   <= 1'b0;
            ev_ovf   <= 1'b0;
            ev_match <= 1'b0;
        end else begin
            count_q  <= nxt;
            ev_ovf   <= wrap;
            ev_match <= hit;
            if (!start)              halt_q <= 1'b0;
            else if (wrap && !reload) halt_q <= 1'b1;
        end
    end

    assign count = count_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!start && !wr_en && !trg_wr) |=> $stable(count));
    assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (wrap && reload) |=> (count == $past(load_val)) && ev_ovf);
    assert_oneshot_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap && !reload) |=> (count == '0) && !run);
    assert_write_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (count == $past(wr_val)) && !ev_ovf && !ev_match);

endmodule

// File: rtl/ccp_capture.sv
module ccp_capture
    import ccp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_in,
    input  capm_e            mode,
    input  logic             second,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap1,
    output logic [CNT_W-1:0] cap2,
    output logic             ev_cap
);
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q, rise, fall, edge_ev;
    slot_e             slot_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= cap_in;
    end

    for (genvar g = 1; g < SYNC_N; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b0;
            else     sync_q[g] <= sync_q[g-1];
        end
    end

    always_comb begin
        rise = sync_q[SYNC_N-1] && !prev_q;
        fall = !sync_q[SYNC_N-1] && prev_q;
        case (mode)
            CAP_RISE: edge_ev = rise;
            CAP_FALL: edge_ev = fall;
            CAP_BOTH: edge_ev = rise || fall;
            default:  edge_ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            slot_q <= SLOT_IDLE;
            cap1   <= '0;
            cap2   <= '0;
            ev_cap <= 1'b0;
        end else begin
            prev_q <= sync_q[SYNC_N-1];
            ev_cap <= 1'b0;
            if (clr) begin
                slot_q <= SLOT_IDLE;
            end else if (edge_ev && slot_q != SLOT_DONE) begin
                if (!second) begin
                    cap1   <= count;
                    ev_cap <= 1'b1;
                    slot_q <= SLOT_DONE;
                end else if (slot_q == SLOT_IDLE) begin
                    slot_q <= SLOT_ONE;
                end else begin
                    cap2   <= count;
                    ev_cap <= 1'b1;
                    slot_q <= SLOT_DONE;
                end
            end
        end
    end

    assert_off_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == CAP_OFF) |=> !ev_cap);
    assert_single_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_cap && !clr) |=> !ev_cap);

endmodule

// File: rtl/ccp_wave.sv
module ccp_wave
    import ccp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic toggle,
    input  trg_e trg,
    input  logic idle_hi,
    input  logic wrap,
    input  logic hit,
    output logic pwm_out
);
    logic inv_q, active, evt;

    always_comb begin
        active  = run && trg_active(trg);
        evt     = trg_hits(trg, wrap, hit);
        pwm_out = active ? (idle_hi ^ inv_q) : idle_hi;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) inv_q <= 1'b0;
        else if (tick)      inv_q <= toggle ? (inv_q ^ evt) : evt;
    end

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !active |=> !inv_q);
    assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !toggle && evt) |=> inv_q);
    assert_toggle_R12: assert property (@(posedge clk) disable iff (rst)
        (active && tick && toggle && evt) |=> (inv_q != $past(inv_q)));

endmodule

// File: rtl/ccp_timer_core.sv
module ccp_timer_core
    import ccp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [14:0]      ctl_word,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_val,
    input  logic             trig_wr,
    input  logic             cap_in,
    input  logic             cap_clr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_first,
    output logic [CNT_W-1:0] cap_second,
    output logic             pwm_out,
    output logic             pin_is_input,
    output logic             ev_match,
    output logic             ev_ovf,
    output logic             ev_cap
);
    ctl_t ctl;
    logic run, tick, wrap, hit;

    assign ctl          = ctl_t'(ctl_word);
    assign pin_is_input = ctl.pin_in;

    ccp_prescaler u_pre (
        .clk(clk), .rst(rst), .run(run), .pre_en(ctl.pre_en),
        .ptv(ctl.ptv), .tick(tick)
    );

    ccp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .start(ctl.start), .reload(ctl.reload),
        .cmp_en(ctl.cmp_en), .tick(tick), .wr_en(cnt_wr_en),
        .wr_val(cnt_wr_val), .trg_wr(trig_wr), .load_val(load_val),
        .match_val(match_val), .count(count), .run(run), .wrap(wrap),
        .hit(hit), .ev_ovf(ev_ovf), .ev_match(ev_match)
    );

    ccp_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .cap_in(cap_in), .mode(ctl.capm),
        .second(ctl.cap_sec), .clr(cap_clr), .count(count),
        .cap1(cap_first), .cap2(cap_second), .ev_cap(ev_cap)
    );

    ccp_wave u_wave (
        .clk(clk), .rst(rst), .run(run), .tick(tick), .toggle(ctl.toggle),
        .trg(ctl.trg), .idle_hi(ctl.idle_hi), .wrap(wrap), .hit(hit),
        .pwm_out(pwm_out)
    );

    assert_dir_R13: assert property (@(posedge clk) disable iff (rst)
        pin_is_input == ctl_word[14]);

endmodule

// File: tb/test_ccp_timer_core.sv
module test_ccp_timer_core;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       c_start = 0, c_reload = 0, c_pre = 0, c_cmp = 0, c_idle = 0;
    logic       c_tog = 0, c_sec = 0, c_pin = 0;
    logic [2:0] c_ptv = 0;
    logic [1:0] c_capm = 0, c_trg = 0;
    logic [W-1:0] load_val = 0, match_val = 0, cnt_wr_val = 0;
    logic cnt_wr_en = 0, trig_wr = 0, cap_in = 0, cap_clr = 0;
    logic [14:0] ctl_word;
    assign ctl_word = {c_pin, c_sec, c_tog, c_trg, c_capm, c_idle, c_cmp, c_pre, c_ptv, c_reload, c_start};

    logic [W-1:0] count, cap_first, cap_second;
    logic pwm_out, pin_is_input, ev_match, ev_ovf, ev_cap;

    ccp_timer_core #(.CNT_W(W)) i_ccp_timer_core (
        .clk(clk), .rst(rst), .ctl_word(ctl_word), .load_val(load_val),
        .match_val(match_val), .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
        .trig_wr(trig_wr), .cap_in(cap_in), .cap_clr(cap_clr), .count(count),
        .cap_first(cap_first), .cap_second(cap_second), .pwm_out(pwm_out),
        .pin_is_input(pin_is_input), .ev_match(ev_match), .ev_ovf(ev_ovf),
        .ev_cap(ev_cap)
    );

    int total = 0, bad = 0;
    string tag = "R1";
    bit cmp_on = 0;

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_cnt, m_div, m_cap1, m_cap2, m_seen;
    bit m_halt, m_inv, m_evm, m_evo, m_evc, m_s1, m_s2, m_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_div = 0; m_cap1 = 0; m_cap2 = 0; m_seen = 0;
            m_halt = 0; m_inv = 0; m_evm = 0; m_evo = 0; m_evc = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            bit running, tk, stp, wr, hitm, act, ev, edg;
            int nxt, lim;
            running = c_start && !m_halt;
            lim = c_pre ? ((1 << (c_ptv + 1)) - 1) : 0;
            tk = running && (m_div == lim);
            stp = tk && !cnt_wr_en && !trig_wr;
            wr = stp && (m_cnt == MAX);
            if (cnt_wr_en)    nxt = cnt_wr_val;
            else if (trig_wr) nxt = load_val;
            else if (wr)      nxt = c_reload ? int'(load_val) : 0;
            else if (stp)     nxt = m_cnt + 1;
            else              nxt = m_cnt;
            hitm = c_cmp && stp && (nxt == match_val);
            act = running && (c_trg == 1 || c_trg == 2);
            ev = (c_trg == 1 && wr) || (c_trg == 2 && (wr || hitm));
            if (!act) m_inv = 0;
            else if (tk) m_inv = c_tog ? (m_inv ^ ev) : ev;
            case (c_capm)
                2'd1: edg = m_s2 && !m_prev;
                2'd2: edg = !m_s2 && m_prev;
                2'd3: edg = m_s2 != m_prev;
                default: edg = 0;
            endcase
            m_evc = 0;
            if (cap_clr) m_seen = 0;
            else if (edg && m_seen < 2) begin
                if (!c_sec) begin m_cap1 = m_cnt; m_evc = 1; m_seen = 2; end
                else if (m_seen == 0) m_seen = 1;
                else begin m_cap2 = m_cnt; m_evc = 1; m_seen = 2; end
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = cap_in;
            m_div = (!running || tk) ? 0 : (m_div + 1) % 256;
            if (!c_start) m_halt = 0;
            else if (wr && !c_reload) m_halt = 1;
            m_cnt = nxt; m_evo = wr; m_evm = hitm;
        end
    end

    always begin
        @(posedge clk);
        #5;
        if (cmp_on) begin
            bit act;
            act = c_start && !m_halt && (c_trg == 1 || c_trg == 2);
            chk("count", count, m_cnt);
            chk("ev_ovf", ev_ovf, m_evo);
            chk("ev_match", ev_match, m_evm);
            chk("ev_cap", ev_cap, m_evc);
            chk("cap_first", cap_first, m_cap1);
            chk("cap_second", cap_second, m_cap2);
            chk("pwm_out", pwm_out, act ? (c_idle ^ m_inv) : c_idle);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stop_clean();
        c_start = 0; cyc(2);
    endtask

    task automatic edges(int n, int gap);
        for (int i = 0; i < n; i++) begin cap_in = ~cap_in; cyc(gap); end
    endtask

    bit finished = 0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        c_idle = 1;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        tag = "R1";
        chk("count", count, 0); chk("cap_first", cap_first, 0);
        chk("cap_second", cap_second, 0); chk("ev_ovf", ev_ovf, 0);
        chk("ev_match", ev_match, 0); chk("ev_cap", ev_cap, 0);
        chk("pwm_out idle", pwm_out, 1);
        cmp_on = 1;
        c_idle = 0;
        // R13 pin direction
        tag = "R13";
        c_pin = 1; #1 chk("pin_is_input", pin_is_input, 1);
        c_pin = 0; #1 chk("pin_is_input", pin_is_input, 0);
        cyc(1);
        // R2 hold and plain counting
        tag = "R2";
        cyc(4);
        c_start = 1; cyc(20);
        chk("count after 20", count, 20);
        stop_clean();
        // R3 prescaler
        tag = "R3";
        c_pre = 1; c_ptv = 0; c_start = 1; cyc(30);
        stop_clean();
        c_ptv = 3; c_start = 1; cyc(100);
        stop_clean(); c_pre = 0;
        // R4 auto-reload
        tag = "R4";
        c_reload = 1; load_val = 8'hF0;
        cnt_wr_en = 1; cnt_wr_val = 8'hFA; cyc(1); cnt_wr_en = 0;
        c_start = 1; cyc(40);
        stop_clean();
        // R5 one-shot
        tag = "R5";
        c_reload = 0;
        cnt_wr_en = 1; cnt_wr_val = 8'hFC; cyc(1); cnt_wr_en = 0;
        c_start = 1; cyc(15);
        chk("halted count", count, 0);
        c_start = 0; cyc(1); c_start = 1; cyc(10);
        stop_clean();
        // R6 writes
        tag = "R6";
        c_reload = 1; load_val = 8'h30; c_start = 1; cyc(3);
        cnt_wr_en = 1; trig_wr = 1; cnt_wr_val = 8'h77; cyc(1);
        cnt_wr_en = 0; cyc(3); cyc(1);
        trig_wr = 0; cyc(3);
        cnt_wr_en = 1; cnt_wr_val = 8'hFF; cyc(1); cnt_wr_en = 0; cyc(4);
        stop_clean();
        // R7 compare
        tag = "R7";
        c_cmp = 1; match_val = 8'h10; load_val = 8'h08;
        cnt_wr_en = 1; cnt_wr_val = 8'h10; cyc(1); cnt_wr_en = 0;
        c_start = 1; cyc(260);
        trig_wr = 1; load_val = 8'h10; cyc(1); trig_wr = 0; cyc(3);
        stop_clean();
        // R8 / R9 capture
        c_start = 1;
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                tag = (s == 0) ? "R8" : "R9";
                c_capm = m[1:0]; c_sec = s[0];
                cap_clr = 1; cyc(1); cap_clr = 0;
                edges(5, 6);
                cap_clr = 1; cyc(1); cap_clr = 0;
                edges(4, 3);
            end
        end
        tag = "R9";
        c_capm = 2'd3; c_sec = 0; cap_clr = 1; cyc(1); cap_clr = 0;
        cap_in = ~cap_in; cyc(2); cap_clr = 1; cyc(1); cap_clr = 0; cyc(5);
        c_capm = 0;
        stop_clean();
        // R10 idle level
        tag = "R10";
        c_idle = 1; c_trg = 0; c_reload = 1; load_val = 8'hF8; c_start = 1; cyc(30);
        c_trg = 3; cyc(30);
        c_start = 0; c_trg = 1; cyc(5);
        // R11 pulse style
        tag = "R11";
        c_idle = 0; c_tog = 0; c_pre = 1; c_ptv = 0; c_start = 1; cyc(80);
        c_trg = 2; match_val = 8'hFB; cyc(80);
        stop_clean();
        // R12 toggle style
        tag = "R12";
        c_tog = 1; c_trg = 1; c_pre = 0; c_start = 1; cyc(60);
        c_trg = 2; c_idle = 1; cyc(60);
        stop_clean();
        cyc(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule